// File: doc/BRIEF.md
# Dynamic Clock Phase Stepper

This block drives the variable phase-shift port of a clock-management tile and runs in that port's clock domain. Software or a higher-level controller presents a signed target phase, expressed in 1/256ths of the input clock period, together with a shift mode and a code that says how the input period compares with the tile's fine-shift range. The block works out the legal phase window for that mode and period range and clamps the target into it. It then walks the tile's phase toward the clamped target one unit at a time.

Each unit is a handshake. The block pulses a one-cycle step strobe with a direction bit and then waits for the tile's one-cycle completion pulse before it issues the next strobe. It keeps its own count of the applied phase. It reports whether it is busy and whether the count matches the target. A sticky flag records any target that had to be clamped. A second sticky flag records a step whose completion never came within a programmable number of cycles. After such a timeout the block gives up on that step and returns to idle.

In fixed mode the block issues no steps. It takes the clamped target as its phase once, on the first clock after reset.

Top module: `phase_step_ctrl`

## Requirements
- R1: `ps_en_o` is high for exactly one clock per step. After a strobe, no further strobe appears until a completion pulse has been accepted or the step has timed out.
- R2: When the strobe is high, `ps_inc_o` is 1 if the clamped target is above the current phase and 0 if it is below.
- R3: `phase_o` changes by +1 or -1, following the direction of the outstanding step, on the clock edge that samples `ps_done_i` high while a step is outstanding. A `ps_done_i` pulse with no step outstanding leaves `phase_o` unchanged.
- R4: When `range_i`=0 (input period twice the fine-shift range), the legal windows are: fixed (`mode_i`=0) -128..128, variable-positive (`mode_i`=1) 0..128, variable-center (`mode_i`=2) -64..64.
- R5: When `range_i`=1 (input period at or below the fine-shift range), the legal windows are: fixed -255..255, variable-positive 0..255, variable-center -255..255. Direct mode (`mode_i`=3) uses 0..1023 for either range.
- R6: A target outside the window is replaced by the nearer limit. `sat_o` rises on the edge that samples such a target and stays high until reset.
- R7: `busy_o` rises together with the first strobe. It falls on the edge that accepts the completion pulse which brings the phase to the target. It also falls when a step times out.
- R8: `at_tgt_o` is combinational and is high exactly when `phase_o` equals the clamped target of the present inputs.
- R9: In fixed mode no strobe is issued. `phase_o` is loaded with the clamped target on the first edge after reset and is then held.
- R10: With `tmo_i`=T (T at least 1), a completion pulse sampled on any of the T edges after the strobe's launch edge is accepted. If there is none, `err_o` is set on the T-th edge, stays set until reset, `busy_o` drops, and the block returns to idle and may retry.
- R11: During reset, `ps_en_o`, `ps_inc_o`, `busy_o`, `sat_o` and `err_o` are 0, and `phase_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase-shift port clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Shift mode: 0 fixed, 1 variable-positive, 2 variable-center, 3 direct |
| range_i | input | 1 | 0: input period twice fine range; 1: period at or below fine range |
| target_i | input | PH_W | Signed requested phase in 1/256 period units |
| tmo_i | input | TMO_W | Completion timeout in clocks, at least 1 |
| ps_done_i | input | 1 | One-cycle step completion from the tile |
| ps_en_o | output | 1 | One-cycle step strobe |
| ps_inc_o | output | 1 | Step direction, 1 increase, 0 decrease |
| phase_o | output | PH_W | Signed current phase count |
| busy_o | output | 1 | Stepping toward target |
| at_tgt_o | output | 1 | Phase equals clamped target |
| sat_o | output | 1 | Sticky: a target was clamped |
| err_o | output | 1 | Sticky: a step timed out |

## Verification
Strobe, direction, busy and the sticky flags are registered, so each is due on the first edge after the inputs that cause it. The phase count changes on the same edge that samples the completion pulse, and `at_tgt_o` follows the inputs in the same cycle. The bench drives every input at the falling edge and advances a behavioural model once for the coming rising edge. At the next falling edge it compares all seven outputs against the model, so each result is checked in exactly the cycle it is due. A modelled delay line returns the completion a set number of edges after each strobe. The delay is varied, including the exact timeout boundary and a line that never answers.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;
  typedef enum logic [1:0] {
    PS_FIXED  = 2'd0,
    PS_VPOS   = 2'd1,
    PS_VCTR   = 2'd2,
    PS_DIRECT = 2'd3
  } ps_mode_e;

  localparam int unsigned LIM_FULL   = 255;
  localparam int unsigned LIM_HALF   = 128;
  localparam int unsigned LIM_CTR    = 64;
  localparam int unsigned LIM_DIRECT = 1023;
endpackage

// File: rtl/phase_lim.sv
module phase_lim
  import phase_step_pkg::*;
#(
  parameter int PH_W = 11
) (
  input  logic [1:0]             mode_i,
  input  logic                   range_i,
  input  logic signed [PH_W-1:0] target_i,
  output logic signed [PH_W-1:0] tgt_o,
  output logic                   oor_o
);
  localparam logic signed [PH_W-1:0] P_FULL = PH_W'(LIM_FULL);
  localparam logic signed [PH_W-1:0] P_HALF = PH_W'(LIM_HALF);
  localparam logic signed [PH_W-1:0] P_CTR  = PH_W'(LIM_CTR);
  localparam logic signed [PH_W-1:0] P_DIR  = PH_W'(LIM_DIRECT);
  localparam logic signed [PH_W-1:0] N_FULL = -P_FULL;
  localparam logic signed [PH_W-1:0] N_HALF = -P_HALF;
  localparam logic signed [PH_W-1:0] N_CTR  = -P_CTR;
  localparam logic signed [PH_W-1:0] ZERO   = '0;

  logic signed [PH_W-1:0] lo, hi;

  always_comb begin
    unique case (ps_mode_e'(mode_i))
      PS_FIXED: begin
        lo = range_i ? N_FULL : N_HALF;
        hi = range_i ? P_FULL : P_HALF;
      end
      PS_VPOS: begin
        lo = ZERO;
        hi = range_i ? P_FULL : P_HALF;
      end
      PS_VCTR: begin
        lo = range_i ? N_FULL : N_CTR;
        hi = range_i ? P_FULL : P_CTR;
      end
      default: begin
        lo = ZERO;
        hi = P_DIR;
      end
    endcase
  end

  always_comb begin
    oor_o = 1'b1;
    if (target_i < lo)      tgt_o = lo;
    else if (target_i > hi) tgt_o = hi;
    else begin
      tgt_o = target_i;
      oor_o = 1'b0;
    end
  end
endmodule

// File: rtl/phase_hs.sv
module phase_hs #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             inc_i,
  input  logic             done_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             ps_en_o,
  output logic             ps_inc_o,
  output logic             wait_o,
  output logic             ack_o,
  output logic             tmo_hit_o
);
  typedef enum logic {HS_IDLE, HS_WAIT} hs_st_e;

  hs_st_e           st_q;
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] tmo_last;

  assign tmo_last  = tmo_i - TMO_W'(1);
  assign wait_o    = (st_q == HS_WAIT);
  assign ack_o     = wait_o && done_i;
  assign tmo_hit_o = wait_o && !done_i && (cnt_q == tmo_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= HS_IDLE;
      cnt_q    <= '0;
      ps_en_o  <= 1'b0;
      ps_inc_o <= 1'b0;
    end else begin
      ps_en_o <= 1'b0;
      if (st_q == HS_IDLE) begin
        if (issue_i) begin
          st_q     <= HS_WAIT;
          ps_en_o  <= 1'b1;
          ps_inc_o <= inc_i;
          cnt_q    <= '0;
        end
      end else if (ack_o || tmo_hit_o) begin
        st_q <= HS_IDLE;
      end else begin
        cnt_q <= cnt_q + TMO_W'(1);
      end
    end
  end

  AST_EN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_en_o |=> !ps_en_o); // R1
  AST_NO_EN_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !ack_o && !tmo_hit_o) |=> !ps_en_o); // R1
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phase_step_pkg::*;
#(
  parameter int PH_W  = 11,
  parameter int TMO_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             mode_i,
  input  logic                   range_i,
  input  logic signed [PH_W-1:0] target_i,
  input  logic [TMO_W-1:0]       tmo_i,
  input  logic                   ps_done_i,
  output logic                   ps_en_o,
  output logic                   ps_inc_o,
  output logic signed [PH_W-1:0] phase_o,
  output logic                   busy_o,
  output logic                   at_tgt_o,
  output logic                   sat_o,
  output logic                   err_o
);
  logic signed [PH_W-1:0] tgt_c, phase_q, phase_step;
  logic oor, fixed, issue, init_q, hs_wait, ack, tmo_hit;
  logic busy_q, sat_q, err_q;

  phase_lim #(.PH_W(PH_W)) u_lim (
    .mode_i   (mode_i),
    .range_i  (range_i),
    .target_i (target_i),
    .tgt_o    (tgt_c),
    .oor_o    (oor)
  );

  assign fixed = (mode_i == PS_FIXED);
  assign issue = init_q && !hs_wait && !fixed && (phase_q != tgt_c);

  phase_hs #(.TMO_W(TMO_W)) u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue),
    .inc_i     (tgt_c > phase_q),
    .done_i    (ps_done_i),
    .tmo_i     (tmo_i),
    .ps_en_o   (ps_en_o),
    .ps_inc_o  (ps_inc_o),
    .wait_o    (hs_wait),
    .ack_o     (ack),
    .tmo_hit_o (tmo_hit)
  );

  assign phase_step = ps_inc_o ? phase_q + PH_W'(1) : phase_q - PH_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b0;
      phase_q <= '0;
      busy_q  <= 1'b0;
      sat_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      init_q <= 1'b1;
      sat_q  <= sat_q | oor;
      err_q  <= err_q | tmo_hit;
      // fixed mode: one-time capture of the clamped target
      if (!init_q && fixed) phase_q <= tgt_c;
      else if (ack)         phase_q <= phase_step;
      if (issue)            busy_q <= 1'b1;
      else if (ack)         busy_q <= (phase_step != tgt_c) && !fixed;
      else if (tmo_hit)     busy_q <= 1'b0;
      else if (!hs_wait)    busy_q <= 1'b0;
    end
  end

  assign phase_o  = phase_q;
  assign busy_o   = busy_q;
  assign sat_o    = sat_q;
  assign err_o    = err_q;
  assign at_tgt_o = (phase_q == tgt_c);

  AST_PHASE_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(init_q) |-> ((phase_q == $past(phase_q)) ||
                       (phase_q == $past(phase_q) + PH_W'(1)) ||
                       (phase_q == $past(phase_q) - PH_W'(1)))); // R3
  AST_IDLE_DONE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !hs_wait && ps_done_i) |=> (phase_q == $past(phase_q))); // R3
  AST_BUSY_WITH_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_en_o |-> busy_o); // R7
  AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |=> sat_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
  AST_FIXED_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fixed && !hs_wait) |=> !ps_en_o); // R9
endmodule

// File: tb/phase_step_ctrl_bench.sv
`timescale 1ns/1ps
module phase_step_ctrl_bench;
  localparam int PH_W  = 11;
  localparam int TMO_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]             mode;
  logic                   rng;
  logic signed [PH_W-1:0] tgt;
  logic [TMO_W-1:0]       tmo;
  logic                   done;
  logic                   ps_en, ps_inc, busy, at_tgt, sat, err;
  logic signed [PH_W-1:0] phase;

  phase_step_ctrl #(.PH_W(PH_W), .TMO_W(TMO_W)) u_phase_step_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .range_i(rng), .target_i(tgt),
    .tmo_i(tmo), .ps_done_i(done), .ps_en_o(ps_en), .ps_inc_o(ps_inc),
    .phase_o(phase), .busy_o(busy), .at_tgt_o(at_tgt), .sat_o(sat), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  int m_init, m_phase, m_busy, m_sat, m_err, m_st, m_en, m_inc, m_cnt;
  int dly = 2, dcnt = 0;
  bit resp_on = 1'b1, stray = 1'b0;

  function automatic int clampv(int md, int rg, int t);
    int lo, hi;
    case (md)
      0: begin lo = rg ? -255 : -128; hi = rg ? 255 : 128; end
      1: begin lo = 0;                 hi = rg ? 255 : 128; end
      2: begin lo = rg ? -255 : -64;  hi = rg ? 255 : 64;  end
      default: begin lo = 0; hi = 1023; end
    endcase
    if (t < lo) return lo;
    if (t > hi) return hi;
    return t;
  endfunction

  function automatic int cur_tc();
    return clampv(int'(mode), int'(rng), int'(tgt));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R1", "ps_en", int'(ps_en), m_en);
    check("R2", "ps_inc", int'(ps_inc), m_inc);
    check("R3", "phase", int'(phase), m_phase);
    check("R7", "busy", int'(busy), m_busy);
    check("R8", "at_tgt", int'(at_tgt), int'(m_phase == cur_tc()));
    check("R6", "sat", int'(sat), m_sat);
    check("R10", "err", int'(err), m_err);
  endtask

  task automatic model_reset();
    m_init = 0; m_phase = 0; m_busy = 0; m_sat = 0; m_err = 0;
    m_st = 0; m_en = 0; m_inc = 0; m_cnt = 0; dcnt = 0;
  endtask

  task automatic step_model();
    int tc, nph, nbusy;
    bit fx, issue, ack, to;
    tc    = cur_tc();
    fx    = (mode == 2'd0);
    issue = (m_st == 0) && (m_init != 0) && !fx && (m_phase != tc);
    ack   = (m_st == 1) && done;
    to    = (m_st == 1) && !done && (m_cnt == int'(tmo) - 1);
    if (m_init == 0 && fx) nph = tc;
    else if (ack)          nph = m_phase + (m_inc != 0 ? 1 : -1);
    else                   nph = m_phase;
    if (issue)          nbusy = 1;
    else if (ack)       nbusy = int'((nph != tc) && !fx);
    else if (to)        nbusy = 0;
    else if (m_st == 0) nbusy = 0;
    else                nbusy = m_busy;
    if (m_st == 0) begin
      m_en = 0;
      if (issue) begin m_st = 1; m_en = 1; m_inc = int'(tc > m_phase); m_cnt = 0; end
    end else begin
      m_en = 0;
      if (ack || to) m_st = 0;
      else m_cnt++;
    end
    if (tc != int'(tgt)) m_sat = 1;
    if (to) m_err = 1;
    m_phase = nph;
    m_busy  = nbusy;
    m_init  = 1;
  endtask

  task automatic cyc();
    if (m_en != 0) dcnt = dly;
    done = rst_n && ((resp_on && dcnt == 1) || stray);
    if (dcnt > 0) dcnt--;
    stray = 1'b0;
    if (rst_n) step_model();
    else model_reset();
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    check("R11", "reset phase", int'(phase), 0);
    check("R11", "reset ps_en", int'(ps_en), 0);
    check("R11", "reset busy", int'(busy), 0);
    check("R11", "reset sat", int'(sat), 0);
    check("R11", "reset err", int'(err), 0);
    rst_n = 1'b1;
  endtask

  task automatic settle();
    int guard = 0;
    cyc();
    while (!(m_st == 0 && m_en == 0 && m_busy == 0 && m_phase == cur_tc()) && guard < 30000) begin
      cyc();
      guard++;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    mode = 2'd0; rng = 1'b0; tgt = 11'sd100; tmo = 8'd20; done = 1'b0;
    model_reset();
    @(negedge clk);
    // fixed mode: capture at reset, then hold (R9)
    do_reset();
    repeat (5) cyc();
    check("R9", "fixed capture", int'(phase), 100);
    tgt = 11'sd300;
    repeat (5) cyc();
    check("R9", "fixed hold", int'(phase), 100);
    check("R6", "fixed clamp sat", int'(sat), 1);

    mode = 2'd1; tgt = '0;
    do_reset();
    tgt = 11'sd5;  settle(); check("R2", "step up to 5", int'(phase), 5);
    tgt = 11'sd200; settle(); check("R4", "vpos long clamp", int'(phase), 128);
    check("R6", "sat after clamp", int'(sat), 1);
    mode = 2'd2; tgt = -11'sd100; settle(); check("R4", "vctr long clamp", int'(phase), -64);
    rng = 1'b1; tgt = -11'sd300; settle(); check("R5", "vctr short clamp", int'(phase), -255);
    mode = 2'd1; tgt = 11'sd300; settle(); check("R5", "vpos short clamp", int'(phase), 255);
    stray = 1'b1;
    repeat (4) cyc();
    check("R3", "stray done ignored", int'(phase), 255);
    mode = 2'd3; tgt = 11'sd1023; settle(); check("R5", "direct upper", int'(phase), 1023);
    tgt = -11'sd5; settle(); check("R5", "direct lower clamp", int'(phase), 0);
    dly = 1; tgt = 11'sd3; settle(); check("R3", "fast done", int'(phase), 3);
    dly = 20; tgt = 11'sd4; settle();
    check("R10", "done on last edge accepted", int'(phase), 4);
    check("R10", "no error at boundary", int'(err), 0);
    dly = 2; resp_on = 1'b0; tgt = 11'sd10;
    repeat (60) cyc();
    check("R10", "timeout error", int'(err), 1);
    check("R10", "no phase move on timeout", int'(phase), 4);
    resp_on = 1'b1; settle(); check("R10", "recovers after timeout", int'(phase), 10);
    mode = 2'd0; tgt = -11'sd20;
    repeat (10) cyc();
    check("R9", "fixed mode later holds", int'(phase), 10);
    check("R9", "fixed mode no strobe", int'(ps_en), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule